// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block is the device-side controller for a fast buffered programming mode of a NOR-style flash array. A host opens a session by writing a setup code and then a confirm code to the first-word address of the region it wants to program. The sequencer then runs a short, fixed-length check on three things: that the address is aligned, that the target block is unlocked and that the programming voltage is valid. If all three pass, it enters a streaming phase. In that phase every write to the held address is taken as a data word and placed in a word buffer.

Each time the buffer is full, a commit engine copies it word by word into an internal array model and then waits a fixed programming time. While that happens, a busy status bit is set and new words are refused. A write to any address other than the held one ends the session. Any buffer that is only partly filled is dropped, and the session ends after any commit already in progress has finished. During a session every read returns the status byte. After a read-array command, reads return array words.

Top module: `bfp_sequencer`

## Requirements
- R1: A setup code (0x80) followed by a confirm code (0xD0) to the same address starts a session. From the confirm write on, reads return the status byte in bits [7:0], with bit 7 (ready) at 0. All error bits are cleared at confirm.
- R2: If the target block's lock input is 1 when the check window ends, the status reads 0x92 (ready, program error bit 4, lock error bit 1), the session ends and the array is unchanged.
- R3: If the voltage-valid input is 0 when the check window ends, the status reads 0x98 (ready, bit 4, voltage error bit 3) and the array is unchanged.
- R4: If the first-word address has any of its low log2(BUF_WORDS) bits set, the status reads 0x90 and the array is unchanged.
- R5: During streaming, every write to the held address is stored as data, including the values 0x70, 0xB0, 0xD0, 0x80 and 0xFF.
- R6: The array is written only from a full buffer. Words of a partly filled buffer are discarded when the session exits.
- R7: While a buffer commit runs (BUF_WORDS copy cycles plus PROG_CYCLES), status bit 0 is 1 and bit 7 is 0. Streamed writes that arrive in this window are not accepted.
- R8: Successive buffers land at increasing offsets from the first-word address. When the offset passes the last word of the block, it wraps to offset 0 of the same block.
- R9: A write to any address other than the held one ends streaming. The status returns to 0x80 only after any running commit has finished.
- R10: After reset, and in idle after a read-array write (0xFF), a read returns the array word at the read address. Erased words read 0xFFFF.
- R11: Reads are registered. The read-valid output pulses in the cycle after the read strobe, and read data is valid in that same cycle.
- R12: A setup code followed by any write other than a matching confirm cancels the sequence and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data or command code |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| lock_bits | input | BLOCKS | Per-block lock state, 1 means locked |
| vpp_ok | input | 1 | Programming voltage is valid |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |

## Verification
The bench builds the block with a 4-word buffer, 16-word blocks, four blocks, a 3-cycle check window and a 5-cycle programming time. With these values a single session fills several buffers and wraps past the end of a block. Every status value and every array word can be checked exhaustively, block by block. The short commit window lets the bench land writes and exit requests inside a running commit on purpose. Random sessions vary the block, the aligned start offset and the word count, including counts that are not multiples of the buffer size.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_CHECK  = 3'd2,
    ST_STREAM = 3'd3,
    ST_EXIT   = 3'd4
  } bfp_state_e;

  typedef enum logic [1:0] {
    CE_IDLE = 2'd0,
    CE_COPY = 2'd1,
    CE_PROG = 2'd2
  } commit_state_e;

  localparam int SR_READY = 7;
  localparam int SR_PERR  = 4;
  localparam int SR_VERR  = 3;
  localparam int SR_LERR  = 1;
  localparam int SR_BUSY  = 0;

endpackage

// File: rtl/bfp_word_buffer.sv
module bfp_word_buffer #(
  parameter int WORDS  = 256,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/bfp_array_model.sv
module bfp_array_model #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];

  // Reset models the erased state of every cell.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= '1;
      end
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/bfp_commit_engine.sv
module bfp_commit_engine
  import bfp_pkg::*;
#(
  parameter int BUF_WORDS   = 256,
  parameter int PROG_CYCLES = 32,
  parameter int ADDR_W      = 10,
  parameter int BLK_W       = 9,
  localparam int IDX_W      = $clog2(BUF_WORDS),
  localparam int MAXC       = (BUF_WORDS > PROG_CYCLES) ? BUF_WORDS : PROG_CYCLES,
  localparam int CNT_W      = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr
);

  commit_state_e     cs_q, cs_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              base_en;

  always_comb begin
    cs_d    = cs_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    base_en = 1'b0;
    unique case (cs_q)
      CE_IDLE: begin
        if (start) begin
          cs_d    = CE_COPY;
          cnt_d   = '0;
          base_d  = base_addr;
          base_en = 1'b1;
        end
      end
      CE_COPY: begin
        if (cnt_q == CNT_W'(BUF_WORDS - 1)) begin
          cs_d  = CE_PROG;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CE_PROG: begin
        if (cnt_q == CNT_W'(PROG_CYCLES - 1)) begin
          cs_d  = CE_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: cs_d = CE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= CE_IDLE;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      cs_q  <= cs_d;
      cnt_q <= cnt_d;
      if (base_en) begin
        base_q <= base_d;
      end
    end
  end

  assign busy     = (cs_q != CE_IDLE);
  assign arr_we   = (cs_q == CE_COPY);
  assign buf_idx  = IDX_W'(cnt_q);
  // Offset wraps inside the block; block field stays fixed.
  assign arr_addr = {base_q[ADDR_W-1:BLK_W], base_q[BLK_W-1:0] + BLK_W'(cnt_q)};

endmodule

// File: rtl/bfp_sequencer.sv
module bfp_sequencer
  import bfp_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int BUF_WORDS     = 256,
  parameter int BLOCK_WORDS   = 512,
  parameter int BLOCKS        = 2,
  parameter int CHECK_CYCLES  = 4,
  parameter int PROG_CYCLES   = 32,
  parameter logic [DATA_W-1:0] CMD_SETUP   = 16'h0080,
  parameter logic [DATA_W-1:0] CMD_CONFIRM = 16'h00D0,
  parameter logic [DATA_W-1:0] CMD_RDARRAY = 16'h00FF,
  localparam int BLK_W  = $clog2(BLOCK_WORDS),
  localparam int SEL_W  = $clog2(BLOCKS),
  localparam int ADDR_W = BLK_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BLOCKS-1:0] lock_bits,
  input  logic              vpp_ok,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);

  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam int CHK_W = $clog2(CHECK_CYCLES + 1);
  localparam int DEPTH = BLOCKS * BLOCK_WORDS;

  bfp_state_e        st_q, st_d;
  logic [ADDR_W-1:0] wa0_q, wa0_d;
  logic              wa0_en;
  logic [IDX_W-1:0]  fill_q, fill_d;
  logic [BLK_W-1:0]  ptr_q, ptr_d;
  logic [CHK_W-1:0]  chk_q, chk_d;
  logic              perr_q, perr_d;
  logic              verr_q, verr_d;
  logic              lerr_q, lerr_d;
  logic              rdst_q, rdst_d;

  logic              buf_we;
  logic              commit_start;
  logic [ADDR_W-1:0] commit_base;
  logic              eng_busy;
  logic [IDX_W-1:0]  eng_idx;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] buf_rdata;
  logic [DATA_W-1:0] arr_rdata;

  logic              ready;
  logic              show_status;
  logic [7:0]        status;
  logic              hit_wa0;
  logic              misaligned;
  logic              blk_locked;
  logic [SEL_W-1:0]  wa0_blk;

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;
  logic              rdata_en;

  assign wa0_blk     = wa0_q[ADDR_W-1:BLK_W];
  assign hit_wa0     = (bus_addr == wa0_q);
  assign misaligned  = |wa0_q[IDX_W-1:0];
  assign blk_locked  = lock_bits[wa0_blk];
  assign commit_base = {wa0_blk, ptr_q};

  // Session control: next state
  always_comb begin
    st_d         = st_q;
    wa0_d        = wa0_q;
    wa0_en       = 1'b0;
    fill_d       = fill_q;
    ptr_d        = ptr_q;
    chk_d        = chk_q;
    perr_d       = perr_q;
    verr_d       = verr_q;
    lerr_d       = lerr_q;
    rdst_d       = rdst_q;
    buf_we       = 1'b0;
    commit_start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (bus_we) begin
          if (bus_wdata == CMD_SETUP) begin
            st_d   = ST_SETUP;
            wa0_d  = bus_addr;
            wa0_en = 1'b1;
          end else if (bus_wdata == CMD_RDARRAY) begin
            rdst_d = 1'b0;
          end
        end
      end
      ST_SETUP: begin
        if (bus_we) begin
          if (hit_wa0 && (bus_wdata == CMD_CONFIRM)) begin
            st_d   = ST_CHECK;
            chk_d  = '0;
            perr_d = 1'b0;
            verr_d = 1'b0;
            lerr_d = 1'b0;
            rdst_d = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_CHECK: begin
        chk_d = chk_q + 1'b1;
        if (chk_q == CHK_W'(CHECK_CYCLES - 1)) begin
          if (misaligned || blk_locked || !vpp_ok) begin
            st_d   = ST_IDLE;
            perr_d = 1'b1;
            lerr_d = blk_locked;
            verr_d = !vpp_ok;
          end else begin
            st_d   = ST_STREAM;
            fill_d = '0;
            ptr_d  = wa0_q[BLK_W-1:0];
          end
        end
      end
      ST_STREAM: begin
        if (bus_we) begin
          if (!hit_wa0) begin
            st_d = ST_EXIT;
          end else if (!eng_busy) begin
            buf_we = 1'b1;
            if (fill_q == IDX_W'(BUF_WORDS - 1)) begin
              commit_start = 1'b1;
              fill_d       = '0;
              ptr_d        = ptr_q + BLK_W'(BUF_WORDS);
            end else begin
              fill_d = fill_q + 1'b1;
            end
          end
        end
      end
      ST_EXIT: begin
        if (!eng_busy) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Session control: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wa0_q  <= '0;
      fill_q <= '0;
      ptr_q  <= '0;
      chk_q  <= '0;
      perr_q <= 1'b0;
      verr_q <= 1'b0;
      lerr_q <= 1'b0;
      rdst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fill_q <= fill_d;
      ptr_q  <= ptr_d;
      chk_q  <= chk_d;
      perr_q <= perr_d;
      verr_q <= verr_d;
      lerr_q <= lerr_d;
      rdst_q <= rdst_d;
      if (wa0_en) begin
        wa0_q <= wa0_d;
      end
    end
  end

  // Status byte
  assign ready = (st_q == ST_IDLE) || (st_q == ST_SETUP);
  always_comb begin
    status           = '0;
    status[SR_READY] = ready;
    status[SR_PERR]  = perr_q;
    status[SR_VERR]  = verr_q;
    status[SR_LERR]  = lerr_q;
    status[SR_BUSY]  = eng_busy;
  end

  assign show_status = rdst_q || (st_q == ST_CHECK) || (st_q == ST_STREAM) || (st_q == ST_EXIT);

  // Read port: next state and registers
  always_comb begin
    rvalid_d = bus_re;
    rdata_en = bus_re;
    rdata_d  = show_status ? DATA_W'(status) : arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rdata_en) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  bfp_word_buffer #(
    .WORDS  (BUF_WORDS),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (fill_q),
    .wr_data (bus_wdata),
    .rd_idx  (eng_idx),
    .rd_data (buf_rdata)
  );

  bfp_commit_engine #(
    .BUF_WORDS   (BUF_WORDS),
    .PROG_CYCLES (PROG_CYCLES),
    .ADDR_W      (ADDR_W),
    .BLK_W       (BLK_W)
  ) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (commit_start),
    .base_addr (commit_base),
    .busy      (eng_busy),
    .buf_idx   (eng_idx),
    .arr_we    (arr_we),
    .arr_addr  (arr_waddr)
  );

  bfp_array_model #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (arr_we),
    .wr_addr (arr_waddr),
    .wr_data (buf_rdata),
    .rd_addr (bus_addr),
    .rd_data (arr_rdata)
  );

endmodule

// File: rtl/bfp_sequencer_chk.sv
module bfp_sequencer_chk
  import bfp_pkg::*;
#(
  parameter int BUF_WORDS = 256,
  parameter int ADDR_W    = 10,
  parameter int BLK_W     = 9,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input bfp_state_e        st,
  input logic [IDX_W-1:0]  fill,
  input logic [ADDR_W-1:0] wa0,
  input logic              busy,
  input logic              ready,
  input logic              perr,
  input logic              verr,
  input logic              lerr,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              bus_re,
  input logic              bus_rvalid
);

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);

  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (fill == $past(fill)));

  assert_commit_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(fill) == IDX_W'(BUF_WORDS - 1)));

  assert_error_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> (st == ST_IDLE));

  assert_lock_flags_perr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lerr |-> perr);

  assert_vpp_flags_perr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    verr |-> perr);

  assert_write_in_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_addr[ADDR_W-1:BLK_W] == wa0[ADDR_W-1:BLK_W]));

  assert_wa0_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_STREAM) && ($past(st) == ST_STREAM)) |-> $stable(wa0));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);

endmodule

bind bfp_sequencer bfp_sequencer_chk #(
  .BUF_WORDS (BUF_WORDS),
  .ADDR_W    (ADDR_W),
  .BLK_W     (BLK_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st         (st_q),
  .fill       (fill_q),
  .wa0        (wa0_q),
  .busy       (eng_busy),
  .ready      (ready),
  .perr       (perr_q),
  .verr       (verr_q),
  .lerr       (lerr_q),
  .arr_we     (arr_we),
  .arr_addr   (arr_waddr),
  .bus_re     (bus_re),
  .bus_rvalid (bus_rvalid)
);

// File: tb/test_bfp_sequencer.sv
module test_bfp_sequencer;

  localparam int BUFW  = 4;
  localparam int BLKW  = 16;
  localparam int NBLK  = 4;
  localparam int CHKC  = 3;
  localparam int PROGC = 5;
  localparam int AW    = 6;
  localparam int DEPTH = BLKW * NBLK;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic          bus_we;
  logic          bus_re;
  logic [NBLK-1:0] lock_bits;
  logic          vpp_ok;
  logic [15:0]   bus_rdata;
  logic          bus_rvalid;

  int checks;
  int fails;
  bit finished;
  logic [15:0] ref_mem [DEPTH];
  logic [15:0] pend [BUFW];

  bfp_sequencer #(
    .DATA_W       (16),
    .BUF_WORDS    (BUFW),
    .BLOCK_WORDS  (BLKW),
    .BLOCKS       (NBLK),
    .CHECK_CYCLES (CHKC),
    .PROG_CYCLES  (PROGC)
  ) i_bfp_sequencer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .lock_bits  (lock_bits),
    .vpp_ok     (vpp_ok),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    bus_re   = 1'b1;
    @(negedge clk);
    bus_re   = 1'b0;
    v = bus_rdata;
    check("R11 rvalid", 16'(bus_rvalid), 16'h1);
  endtask

  task automatic wait_not_busy();
    logic [15:0] v;
    do rd(0, v); while (v[0]);
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    do rd(0, v); while (!v[7]);
  endtask

  task automatic start_op(logic [AW-1:0] a);
    wr(a, 16'h0080);
    wr(a, 16'h00D0);
    repeat (CHKC + 2) @(negedge clk);
  endtask

  function automatic logic [15:0] pick_word();
    logic [15:0] codes [5] = '{16'h0070, 16'h00B0, 16'h00D0, 16'h0080, 16'h00FF};
    if ($urandom_range(3) == 0) return codes[$urandom_range(4)];
    return 16'($urandom);
  endfunction

  // Place a full buffer in the reference, wrapping inside the block.
  function automatic void model_commit(int blk, int off);
    for (int k = 0; k < BUFW; k++) begin
      ref_mem[blk * BLKW + ((off + k) % BLKW)] = pend[k];
    end
  endfunction

  task automatic stream(logic [AW-1:0] wa0, int n);
    int blk = int'(wa0) / BLKW;
    int off = int'(wa0) % BLKW;
    for (int i = 0; i < n; i++) begin
      logic [15:0] d = pick_word();
      if ((i % BUFW) == 0 && i > 0) wait_not_busy();
      pend[i % BUFW] = d;
      wr(wa0, d);
      if ((i % BUFW) == BUFW - 1) begin
        model_commit(blk, off);
        off = (off + BUFW) % BLKW;
      end
    end
  endtask

  task automatic exit_op(logic [AW-1:0] wa0, string req);
    logic [15:0] v;
    wr(wa0 ^ 6'h1, 16'h1234);
    wait_ready();
    rd(0, v);
    check(req, v, 16'h0080);
  endtask

  task automatic verify_block(int blk, string req);
    logic [15:0] v;
    wr(0, 16'h00FF);
    for (int i = 0; i < BLKW; i++) begin
      rd(AW'(blk * BLKW + i), v);
      check(req, v, ref_mem[blk * BLKW + i]);
    end
  endtask

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed));
    checks = 0; fails = 0; finished = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    lock_bits = '0; vpp_ok = 1'b1;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'hFFFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state reads erased array
    rd(6'd5, v);
    check("R10 reset read", v, 16'hFFFF);

    // R1 + R5: session at block 1, command-valued data included
    wr(6'd16, 16'h0080);
    wr(6'd16, 16'h00D0);
    rd(0, v);
    check("R1 not ready after confirm", v & 16'h0080, 16'h0000);
    repeat (CHKC) @(negedge clk);
    pend = '{16'h0070, 16'h00B0, 16'h00D0, 16'h00FF};
    for (int i = 0; i < BUFW; i++) wr(6'd16, pend[i]);
    model_commit(1, 0);
    wait_not_busy();
    stream(6'd20, 0);
    for (int i = 0; i < BUFW; i++) begin
      pend[i] = 16'hA000 + 16'(i);
      wr(6'd16, pend[i]);
    end
    model_commit(1, 4);
    exit_op(6'd16, "R9 ready after exit");
    verify_block(1, "R5 streamed data");

    // R6: partial buffer dropped
    start_op(6'd32);
    stream(6'd32, 6);
    exit_op(6'd32, "R9 exit");
    verify_block(2, "R6 partial discarded");

    // R8: wrap within block 3
    start_op(6'd56);
    stream(6'd56, 12);
    exit_op(6'd56, "R9 exit");
    verify_block(3, "R8 wrap");

    // R2: locked block
    lock_bits = 4'b0001;
    start_op(6'd0);
    rd(0, v);
    check("R2 lock status", v, 16'h0092);
    lock_bits = '0;
    verify_block(0, "R2 array unchanged");

    // R3: bad programming voltage
    vpp_ok = 1'b0;
    start_op(6'd4);
    rd(0, v);
    check("R3 vpp status", v, 16'h0098);
    vpp_ok = 1'b1;

    // R4: misaligned first-word address
    start_op(6'd2);
    rd(0, v);
    check("R4 misaligned status", v, 16'h0090);
    verify_block(0, "R4 array unchanged");

    // R12: setup without confirm
    wr(6'd0, 16'h0080);
    wr(6'd0, 16'h0055);
    wr(6'd0, 16'h00FF);
    rd(6'd0, v);
    check("R12 abort read", v, 16'hFFFF);
    verify_block(0, "R12 array unchanged");

    // R7: busy window refuses writes
    start_op(6'd0);
    for (int i = 0; i < BUFW; i++) begin
      pend[i] = 16'hB100 + 16'(i);
      wr(6'd0, pend[i]);
    end
    model_commit(0, 0);
    rd(0, v);
    check("R7 busy status", v & 16'h0081, 16'h0001);
    wr(6'd0, 16'hDEAD);
    wait_not_busy();
    for (int i = 0; i < BUFW; i++) begin
      pend[i] = 16'hB200 + 16'(i);
      wr(6'd0, pend[i]);
    end
    model_commit(0, 4);
    exit_op(6'd0, "R9 exit");
    verify_block(0, "R7 write during busy ignored");

    // R9: exit while a commit is running
    start_op(6'd8);
    for (int i = 0; i < BUFW; i++) begin
      pend[i] = 16'hC300 + 16'(i);
      wr(6'd8, pend[i]);
    end
    model_commit(0, 8);
    wr(6'd9, 16'h0000);
    rd(0, v);
    check("R9 not ready during commit", v & 16'h0080, 16'h0000);
    wait_ready();
    rd(0, v);
    check("R9 ready after commit", v, 16'h0080);
    verify_block(0, "R9 commit completed");

    // Random sessions
    for (int s = 0; s < 8; s++) begin
      int blk = $urandom_range(NBLK - 1);
      int off = $urandom_range(BLKW / BUFW - 1) * BUFW;
      int n   = $urandom_range(1, 14);
      logic [AW-1:0] a = AW'(blk * BLKW + off);
      start_op(a);
      stream(a, n);
      exit_op(a, "R9 random exit");
      verify_block(blk, "R8 random session");
    end

    report();
  end

endmodule